// File: doc/BRIEF.md
# Test-and-Set Semaphore Bank

This block holds a small set of one-bit semaphores that several processor ports share. A port acquires a semaphore with a test-and-set request. The block returns the value the semaphore held and leaves it at 1. Reading the value and writing the 1 happen as one step, so no other port can act on that semaphore in between. A returned 0 means the requester now owns the resource. A returned 1 means another agent holds it and the requester must try again later. The owner gives the resource back with a release request, which writes 0.

Every port has its own request strobe, operation bit, semaphore index, response strobe and returned-value bit. All ports are served in the same cycle. When requests meet on one semaphore in the same cycle, the block orders them in a fixed way. Releases are applied first. Test-and-set requests then follow in ascending port number. The lowest-numbered contender therefore sees the real state, and every later contender sees 1. Each response appears exactly one clock after its request.

Top module: `tas_sem_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, every semaphore reads 0 and no response strobe is high. The first test-and-set to any semaphore after reset returns 0.
- R2: A test-and-set (operation bit 0) returns the semaphore's stored value: 0 means acquired, 1 means taken. The semaphore reads 1 afterwards.
- R3: A release (operation bit 1) writes 0 to the addressed semaphore, provided no test-and-set targets it in the same cycle. Its response carries the value held before the release.
- R4: When several ports test-and-set the same semaphore in one cycle, the lowest-numbered of them receives the real value and all the others receive 1. At most one of them ever receives 0.
- R5: When a release and a test-and-set hit the same semaphore in one cycle, the release takes effect first. The lowest-numbered tester then receives 0, and the semaphore ends at 1.
- R6: A port's response strobe is high in exactly the cycle after that port's request. A port that makes no request gets no response.
- R7: Requests to different semaphores do not affect one another. The port index field for port p is idx_i[p*3 +: 3] with the default eight semaphores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | NUM_PORTS | Per-port request strobe |
| op_i | input | NUM_PORTS | Per-port operation: 0 test-and-set, 1 release |
| idx_i | input | NUM_PORTS*IDX_W | Per-port semaphore index, port p in bits p*IDX_W +: IDX_W |
| rsp_valid_o | output | NUM_PORTS | Per-port response strobe, one cycle after the request |
| rsp_old_o | output | NUM_PORTS | Per-port returned semaphore value |

## Verification
The bound checker watches four properties on every cycle:
- the one-cycle response timing;
- that a semaphore reads 1 after any test-and-set;
- that an uncontested release clears its semaphore;
- that two colliding testers are never both told 0.

It also checks the reset state. Only the bench's scenarios can show the returned values themselves. For every semaphore, both starting states and every mix of idle, test-and-set and release across the four ports, the bench compares each returned bit against an arithmetic model. That model applies releases first and then testers in port order. A pseudo-random run then spreads requests over different semaphores, and afterwards each semaphore's state is read back to show that no request disturbed another.

// File: rtl/tas_pkg.sv
// Shared definitions for the test-and-set semaphore bank.
// Assumes: one operation bit per port.
package tas_pkg;
    typedef enum logic {
        SEM_OP_TAS     = 1'b0,
        SEM_OP_RELEASE = 1'b1
    } sem_op_e;
endpackage

// File: rtl/tas_port_decode.sv
// Turns one port's request into one-hot hit vectors over the semaphores:
// one vector for test-and-set and one for release.
// Assumes: the index is below NUM_SEMS. Larger indices hit nothing.
module tas_port_decode #(
    parameter int NUM_SEMS = 8,
    parameter int IDX_W    = 3
) (
    input  logic                req,
    input  logic                op,
    input  logic [IDX_W-1:0]    idx,
    output logic [NUM_SEMS-1:0] tas_hit,
    output logic [NUM_SEMS-1:0] rel_hit
);
    import tas_pkg::*;

    for (genvar k = 0; k < NUM_SEMS; k++) begin : g_sem
        logic sel;
        // Purpose: decide whether this port addresses semaphore k.
        assign sel        = req && (idx == IDX_W'(k));
        assign tas_hit[k] = sel && (sem_op_e'(op) == SEM_OP_TAS);
        assign rel_hit[k] = sel && (sem_op_e'(op) == SEM_OP_RELEASE);
    end
endmodule

// File: rtl/tas_sem_slice.sv
// Resolves one semaphore for one cycle. Releases apply first. Testers
// then take turns in ascending port order: the first sees the state left
// after the releases, and every later tester sees 1. A releaser sees the
// value held at the start of the cycle.
// Assumes: a port does not both test and release in the same cycle.
module tas_sem_slice #(
    parameter int NUM_PORTS = 4
) (
    input  logic                 cur,
    input  logic [NUM_PORTS-1:0] tas_req,
    input  logic [NUM_PORTS-1:0] rel_req,
    output logic                 nxt,
    output logic [NUM_PORTS-1:0] seen
);
    logic after_rel;

    // Purpose: state left once all releases of this cycle are applied.
    assign after_rel = cur & ~(|rel_req);

    // Purpose: value each port observes, served in fixed port priority.
    always_comb begin
        logic taken_earlier;
        taken_earlier = 1'b0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (rel_req[p]) begin
                seen[p] = cur;
            end else if (taken_earlier) begin
                seen[p] = 1'b1;
            end else begin
                seen[p] = after_rel;
            end
            taken_earlier = taken_earlier | tas_req[p];
        end
    end

    // Purpose: next stored value; any tester leaves the semaphore set.
    assign nxt = after_rel | (|tas_req);
endmodule

// File: rtl/tas_sem_unit.sv
// Top of the test-and-set semaphore bank. Each port's request is decoded,
// the per-port hits are regrouped per semaphore, each semaphore is
// resolved by a slice, and the state and per-port responses are
// registered.
// Assumes: responses are consumed in the cycle they are shown. There is
// no back-pressure.
module tas_sem_unit #(
    parameter int NUM_PORTS = 4,
    parameter int NUM_SEMS  = 8,
    parameter int IDX_W     = (NUM_SEMS > 1) ? $clog2(NUM_SEMS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_PORTS-1:0]       req_i,
    input  logic [NUM_PORTS-1:0]       op_i,
    input  logic [NUM_PORTS*IDX_W-1:0] idx_i,
    output logic [NUM_PORTS-1:0]       rsp_valid_o,
    output logic [NUM_PORTS-1:0]       rsp_old_o
);
    logic [NUM_SEMS-1:0]  sem_q;
    logic [NUM_SEMS-1:0]  sem_nxt;
    logic [NUM_SEMS-1:0]  tas_hit [NUM_PORTS];
    logic [NUM_SEMS-1:0]  rel_hit [NUM_PORTS];
    logic [NUM_PORTS-1:0] tas_col [NUM_SEMS];
    logic [NUM_PORTS-1:0] rel_col [NUM_SEMS];
    logic [NUM_PORTS-1:0] seen_col [NUM_SEMS];
    logic [NUM_PORTS-1:0] old_nxt;
    logic [NUM_PORTS-1:0] rsp_valid_q;
    logic [NUM_PORTS-1:0] rsp_old_q;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        tas_port_decode #(
            .NUM_SEMS (NUM_SEMS),
            .IDX_W    (IDX_W)
        ) u_dec (
            .req     (req_i[p]),
            .op      (op_i[p]),
            .idx     (idx_i[p*IDX_W +: IDX_W]),
            .tas_hit (tas_hit[p]),
            .rel_hit (rel_hit[p])
        );
        // Purpose: pick this port's observed value from the addressed slice.
        assign old_nxt[p] = seen_col[idx_i[p*IDX_W +: IDX_W]][p];
    end

    for (genvar k = 0; k < NUM_SEMS; k++) begin : g_sem
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_tr
            // Purpose: regroup port-major hits into semaphore-major columns.
            assign tas_col[k][p] = tas_hit[p][k];
            assign rel_col[k][p] = rel_hit[p][k];
        end
        tas_sem_slice #(
            .NUM_PORTS (NUM_PORTS)
        ) u_slice (
            .cur     (sem_q[k]),
            .tas_req (tas_col[k]),
            .rel_req (rel_col[k]),
            .nxt     (sem_nxt[k]),
            .seen    (seen_col[k])
        );
    end

    // Purpose: hold the semaphore bits; all free after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sem_q <= '0;
        end else begin
            sem_q <= sem_nxt;
        end
    end

    // Purpose: register one response per requesting port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= '0;
            rsp_old_q   <= '0;
        end else begin
            rsp_valid_q <= req_i;
            rsp_old_q   <= req_i & old_nxt;
        end
    end

    assign rsp_valid_o = rsp_valid_q;
    assign rsp_old_o   = rsp_old_q;
endmodule

// File: rtl/tas_sem_checker.sv
// Cycle-by-cycle properties of the semaphore bank, bound into the top.
// Assumes: the same parameters as the instance it is bound to.
module tas_sem_checker #(
    parameter int NUM_PORTS = 4,
    parameter int NUM_SEMS  = 8,
    parameter int IDX_W     = 3
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NUM_PORTS-1:0]       req_i,
    input logic [NUM_PORTS-1:0]       op_i,
    input logic [NUM_PORTS*IDX_W-1:0] idx_i,
    input logic [NUM_PORTS-1:0]       rsp_valid_o,
    input logic [NUM_PORTS-1:0]       rsp_old_o,
    input logic [NUM_SEMS-1:0]        sem_q
);
    logic [NUM_PORTS-1:0]       req_d;
    logic [NUM_PORTS-1:0]       op_d;
    logic [NUM_PORTS*IDX_W-1:0] idx_d;
    logic [NUM_SEMS-1:0]        tas_any;

    // Purpose: remember last cycle's requests to pair them with responses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_d <= '0;
            op_d  <= '0;
            idx_d <= '0;
        end else begin
            req_d <= req_i;
            op_d  <= op_i;
            idx_d <= idx_i;
        end
    end

    // Purpose: flag semaphores that any port tests in this cycle.
    always_comb begin
        tas_any = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (req_i[p] && !op_i[p]) begin
                tas_any[idx_i[p*IDX_W +: IDX_W]] = 1'b1;
            end
        end
    end

    // R1: reset leaves every semaphore free and no response pending.
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (sem_q == '0) && (rsp_valid_o == '0));

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        // R6: a request is answered in the next cycle.
        a_r6_resp_next: assert property (@(posedge clk) disable iff (!rst_n)
            req_i[p] |=> rsp_valid_o[p]);
        // R6: no request, no response.
        a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
            !req_i[p] |=> !rsp_valid_o[p]);
        // R2: a tested semaphore is held afterwards.
        a_r2_set_after_tas: assert property (@(posedge clk) disable iff (!rst_n)
            (req_i[p] && !op_i[p]) |=> sem_q[$past(idx_i[p*IDX_W +: IDX_W])]);
        for (genvar q = p + 1; q < NUM_PORTS; q++) begin : g_pair
            // R4: two colliding testers never both acquire.
            a_r4_one_winner: assert property (@(posedge clk) disable iff (!rst_n)
                (rsp_valid_o[p] && rsp_valid_o[q] && !op_d[p] && !op_d[q] &&
                 req_d[p] && req_d[q] &&
                 (idx_d[p*IDX_W +: IDX_W] == idx_d[q*IDX_W +: IDX_W]))
                |-> (rsp_old_o[p] || rsp_old_o[q]));
        end
    end

    for (genvar k = 0; k < NUM_SEMS; k++) begin : g_sem
        logic rel_here;
        // Purpose: some port releases semaphore k in this cycle.
        always_comb begin
            rel_here = 1'b0;
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (req_i[p] && op_i[p] &&
                    (idx_i[p*IDX_W +: IDX_W] == IDX_W'(k))) begin
                    rel_here = 1'b1;
                end
            end
        end
        // R3: an uncontested release frees the semaphore.
        a_r3_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (rel_here && !tas_any[k]) |=> !sem_q[k]);
    end
endmodule

bind tas_sem_unit tas_sem_checker #(
    .NUM_PORTS (NUM_PORTS),
    .NUM_SEMS  (NUM_SEMS),
    .IDX_W     (IDX_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .op_i        (op_i),
    .idx_i       (idx_i),
    .rsp_valid_o (rsp_valid_o),
    .rsp_old_o   (rsp_old_o),
    .sem_q       (sem_q)
);

// File: tb/sim_tas_sem_unit.sv
`timescale 1ns/1ps
module sim_tas_sem_unit;
    localparam int NP = 4;
    localparam int NS = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] req_i = '0;
    logic [NP-1:0] op_i = '0;
    logic [NP*IW-1:0] idx_i = '0;
    logic [NP-1:0] rsp_valid_o;
    logic [NP-1:0] rsp_old_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [NS-1:0] model = '0;
    logic [NP-1:0] exp_old;
    string tag [NP];

    always #4 clk = ~clk;

    tas_sem_unit #(.NUM_PORTS(NP), .NUM_SEMS(NS)) u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .op_i(op_i), .idx_i(idx_i),
        .rsp_valid_o(rsp_valid_o), .rsp_old_o(rsp_old_o)
    );

    task automatic chk(input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // Drive one request cycle at a falling edge and check the responses
    // at the next falling edge, against the model: releases first, then
    // testers in port order.
    task automatic step(input logic [NP-1:0] rq, input logic [NP-1:0] o,
                        input logic [NP*IW-1:0] ix);
        logic [NS-1:0] tmp;
        logic [NS-1:0] tested;
        logic [NS-1:0] released;
        req_i = rq; op_i = o; idx_i = ix;
        tmp = model; tested = '0; released = '0;
        for (int p = 0; p < NP; p++) begin
            exp_old[p] = 1'b0;
            tag[p] = "R6";
            if (rq[p] && o[p]) begin
                exp_old[p] = model[ix[p*IW +: IW]];
                tmp[ix[p*IW +: IW]] = 1'b0;
                released[ix[p*IW +: IW]] = 1'b1;
                tag[p] = "R3 release old value";
            end
        end
        for (int p = 0; p < NP; p++) begin
            if (rq[p] && !o[p]) begin
                exp_old[p] = tmp[ix[p*IW +: IW]];
                if (tested[ix[p*IW +: IW]]) tag[p] = "R4 collision loser";
                else if (released[ix[p*IW +: IW]]) tag[p] = "R5 release before test";
                else tag[p] = "R2 test-and-set value";
                tmp[ix[p*IW +: IW]] = 1'b1;
                tested[ix[p*IW +: IW]] = 1'b1;
            end
        end
        model = tmp;
        @(posedge clk);
        @(negedge clk);
        req_i = '0;
        for (int p = 0; p < NP; p++) begin
            chk(int'(rsp_valid_o[p]), int'(rq[p]), $sformatf("R6 valid port %0d", p));
            if (rq[p]) chk(int'(rsp_old_o[p]), int'(exp_old[p]),
                           $sformatf("%s port %0d", tag[p], p));
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        chk(int'(rsp_valid_o), 0, "R1 no response during reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk(int'(rsp_valid_o), 0, "R1 no response after reset");
        // R1: every semaphore starts free.
        for (int k = 0; k < NS; k++) begin
            step(4'b0001, 4'b0000, (NP*IW)'(k));
            chk(int'(rsp_old_o[0]), 0, $sformatf("R1 sem %0d free after reset", k));
        end
        for (int k = 0; k < NS; k++) step(4'b0001, 4'b0001, (NP*IW)'(k));
        // Full sweep: every semaphore, both start states, every mix of
        // idle / test-and-set / release over the four ports.
        for (int k = 0; k < NS; k++) begin
            for (int pre = 0; pre < 2; pre++) begin
                for (int combo = 0; combo < 81; combo++) begin
                    logic [NP-1:0] rq;
                    logic [NP-1:0] o;
                    logic [NP*IW-1:0] ix;
                    int c;
                    step(4'b0001, (pre != 0) ? 4'b0000 : 4'b0001, (NP*IW)'(k));
                    c = combo; rq = '0; o = '0; ix = '0;
                    for (int p = 0; p < NP; p++) begin
                        rq[p] = (c % 3) != 0;
                        o[p] = (c % 3) == 2;
                        ix[p*IW +: IW] = IW'(k);
                        c = c / 3;
                    end
                    step(rq, o, ix);
                end
            end
        end
        // R7: mixed indices across ports, then read each semaphore back.
        lfsr = 16'hACE1;
        for (int n = 0; n < 3000; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[3:0], lfsr[7:4], {lfsr[15:8], lfsr[3:0] ^ lfsr[11:8]});
        end
        for (int k = 0; k < NS; k++) begin
            logic expv;
            expv = model[k];
            step(4'b0001, 4'b0000, (NP*IW)'(k));
            chk(int'(rsp_old_o[0]), int'(expv), $sformatf("R7 sem %0d independent state", k));
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule